// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block gathers every reason a small microcontroller core may have to restart and turns them into one synchronous system reset. There are four causes. The first is an external power-on or pin reset, which is asynchronous and active low. The second is a software request strobe. The third is a one-cycle watchdog underflow pulse. The fourth is an oscillator-stop flag from an external detector. Each internal cause passes through its own gate. A software request is honoured only while the main clock drives the CPU and is flagged stable. A watchdog underflow resets only when its enable bit is 1, and otherwise becomes an interrupt pulse. An oscillator stop resets only when its mode bit is 0, and otherwise becomes an interrupt pulse on the rising edge of the flag.

The reset output is held for a fixed number of cycles after the last active cause. While the reset is active the CPU register bank and the program counter are zero. When the reset is released the block reads three bytes from the reset vector at FFFFCh, FFFFDh and FFFFEh. It loads the 20-bit program counter from them and then raises a run flag. A latched cause register records every source that fired. A 2-bit processor-mode field survives internal resets, and so do the bits of a control register selected by a retain mask. A power-on reset clears all of this state.

Top module: `rst_hub`

## Requirements
- R1: A software request (`sw_rst_wr`=1) while `main_clk_sel`=1 and `main_osc_stable`=1 asserts `sys_rst_o` from the next clock edge and sets cause bit 1.
- R2: A software request with `main_clk_sel`=0 or `main_osc_stable`=0 is ignored: `sys_rst_o` stays 0, the cause register stays as it was and `pc_o` is unchanged.
- R3: A watchdog pulse with `wdt_rst_en`=1 resets and sets cause bit 2. With `wdt_rst_en`=0 it does not reset; instead `wdt_irq_o` is 1 for exactly the cycle after the pulse.
- R4: After a two-flop synchroniser, the oscillator-stop flag resets and sets cause bit 3 when `osc_int_mode`=0. When `osc_int_mode`=1 it does not reset, and `osc_irq_o` pulses for one cycle, three edges after the flag rises.
- R5: `mode_o` keeps its value through software, watchdog and oscillator-stop resets. Writes to it are ignored while `sys_rst_o` is 1 or a reset cause is active.
- R6: An internal reset clears the control-register bits where `RETAIN_MASK` is 0 (default 8'hF0) and keeps the others.
- R7: While `por_n` is low `sys_rst_o` is 1. After a power-on reset, `mode_o`=0, `ctl_o`=0 and `cause_o`=4'b0001 (bit 0 = power-on).
- R8: Every reset clears the register bank: indices 0 to 10 are 16-bit registers, and index 11 is the 20-bit interrupt table base. Writes to indices 0 to 10 keep only the low 16 bits.
- R9: After release the block requests FFFFCh, FFFFDh and FFFFEh in that order. It sets `pc_o` to {byte2[3:0], byte1, byte0} and then raises `cpu_run_o`. While `sys_rst_o`=1, `pc_o`=0 and `cpu_run_o`=0.
- R10: `sys_rst_o` stays high for exactly `HOLD` (16) cycles after the last cycle with an active cause, and a new cause restarts the count.
- R11: Cause bits (bit 0 power-on, bit 1 software, bit 2 watchdog, bit 3 oscillator stop) survive internal resets. They clear only on power-on or when 1 is written to them with `cause_clr_wr`. Simultaneous causes all set, and a set wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on/pin reset, active low |
| sw_rst_wr | input | 1 | Software reset request strobe |
| main_clk_sel | input | 1 | 1 when the main clock drives the CPU |
| main_osc_stable | input | 1 | 1 when main oscillation is stable |
| wdt_uflow | input | 1 | Watchdog underflow pulse |
| wdt_rst_en | input | 1 | 1 selects reset on underflow |
| osc_stop | input | 1 | Oscillator-stop detection flag (asynchronous) |
| osc_int_mode | input | 1 | 1 selects interrupt instead of reset on oscillator stop |
| cause_clr_wr | input | 1 | Write strobe for clearing cause bits |
| cause_clr_data | input | 4 | Cause bits to clear (1 clears) |
| mode_wr | input | 1 | Processor-mode write strobe |
| mode_wdata | input | 2 | Processor-mode write data |
| ctl_wr | input | 1 | Control-register write strobe |
| ctl_wdata | input | 8 | Control-register write data |
| reg_wr | input | 1 | Register-bank write strobe |
| reg_sel | input | 4 | Register-bank index |
| reg_wdata | input | 20 | Register-bank write data |
| vec_rvalid | input | 1 | Vector read data valid |
| vec_rdata | input | 8 | Vector read byte |
| sys_rst_o | output | 1 | Stretched system reset |
| cause_o | output | 4 | Latched reset causes |
| mode_o | output | 2 | Processor-mode field |
| ctl_o | output | 8 | Control register |
| reg_rdata | output | 20 | Register-bank read data at `reg_sel` |
| vec_req_o | output | 1 | Vector byte read request |
| vec_addr_o | output | 20 | Vector byte address |
| pc_o | output | 20 | Program counter |
| cpu_run_o | output | 1 | CPU may execute |
| wdt_irq_o | output | 1 | Watchdog interrupt pulse |
| osc_irq_o | output | 1 | Oscillator-stop interrupt pulse |

## Verification
The properties assume several things about the inputs. The software strobe, the watchdog pulse and the cause-clear write are synchronous to `clk`. The vector memory answers only addressed requests. Cause bits can then change only through a trigger or an explicit clear. The stimulus changes every input on the falling edge and holds each watchdog or software pulse for one cycle. It raises the oscillator flag for one full cycle, or for a few cycles in interrupt mode, so the synchroniser always sees a clean level. It makes vector data valid only while a request is outstanding.

// File: rtl/rst_hub_pkg.sv
`timescale 1ns/1ps
package rst_hub_pkg;
    localparam int NCAUSE    = 4;
    localparam int CAUSE_POR = 0;
    localparam int CAUSE_SW  = 1;
    localparam int CAUSE_WDT = 2;
    localparam int CAUSE_OSC = 3;

    typedef enum logic [1:0] {
        PH_HOLD  = 2'd0,
        PH_FETCH = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;
endpackage

// File: rtl/rst_hub_sync.sv
`timescale 1ns/1ps
module rst_hub_sync #(
    parameter int STAGES    = 2,
    parameter bit ASYNC_CLR = 1'b1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    generate
        if (ASYNC_CLR) begin : g_async
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain_q <= '0;
                else         chain_q <= chain_d;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                if (!arst_n) chain_q <= '0;
                else         chain_q <= chain_d;
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rst_hub_cause.sv
`timescale 1ns/1ps
module rst_hub_cause
    import rst_hub_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_req,
    input  logic              clk_sel,
    input  logic              osc_stable,
    input  logic              wdt_uflow,
    input  logic              wdt_rst_en,
    input  logic              osc_flag,
    input  logic              osc_int_mode,
    output logic [NCAUSE-1:0] trig,
    output logic              wdt_irq,
    output logic              osc_irq
);
    typedef struct packed {
        logic osc_prev;
        logic wdt_irq;
        logic osc_irq;
    } cause_st_t;

    cause_st_t s_d, s_q;

    always_comb begin
        trig            = '0;
        trig[CAUSE_SW]  = sw_req & clk_sel & osc_stable;
        trig[CAUSE_WDT] = wdt_uflow & wdt_rst_en;
        trig[CAUSE_OSC] = osc_flag & ~osc_int_mode;

        s_d          = s_q;
        s_d.osc_prev = osc_flag;
        s_d.wdt_irq  = wdt_uflow & ~wdt_rst_en;
        s_d.osc_irq  = osc_flag & ~s_q.osc_prev & osc_int_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wdt_irq = s_q.wdt_irq;
    assign osc_irq = s_q.osc_irq;
endmodule

// File: rtl/rst_hub_stretch.sv
`timescale 1ns/1ps
module rst_hub_stretch #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_any,
    output logic active,
    output logic release_now
);
    localparam int             CW     = $clog2(HOLD + 1);
    localparam logic [CW-1:0]  HOLD_V = CW'(HOLD);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (trig_any)          cnt_d = HOLD_V;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= HOLD_V;
        else        cnt_q <= cnt_d;
    end

    assign active      = (cnt_q != '0);
    assign release_now = (cnt_q == CW'(1)) & ~trig_any;
endmodule

// File: rtl/rst_hub_vfetch.sv
`timescale 1ns/1ps
module rst_hub_vfetch
    import rst_hub_pkg::*;
#(
    parameter int                ADDR_W   = 20,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] VEC_BASE = 20'hFFFFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              release_now,
    input  logic              rvalid,
    input  logic [DATA_W-1:0] rdata,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] pc,
    output logic              run
);
    localparam int NBYTES = (ADDR_W + DATA_W - 1) / DATA_W;
    localparam int IW     = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam int FULL_W = NBYTES * DATA_W;

    typedef struct packed {
        phase_e            phase;
        logic [IW-1:0]     idx;
        logic [FULL_W-1:0] bytes;
        logic [ADDR_W-1:0] pc;
    } vf_st_t;

    vf_st_t            s_d, s_q;
    logic [FULL_W-1:0] merged;

    always_comb begin
        s_d    = s_q;
        merged = s_q.bytes;
        merged[int'(s_q.idx)*DATA_W +: DATA_W] = rdata;

        unique case (s_q.phase)
            PH_HOLD: begin
                if (release_now) begin
                    s_d.phase = PH_FETCH;
                    s_d.idx   = '0;
                end
            end
            PH_FETCH: begin
                if (rvalid) begin
                    s_d.bytes = merged;
                    if (int'(s_q.idx) == NBYTES - 1) begin
                        s_d.pc    = merged[ADDR_W-1:0];
                        s_d.phase = PH_RUN;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            default: ;
        endcase

        if (restart) begin
            s_d.phase = PH_HOLD;
            s_d.idx   = '0;
            s_d.pc    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{phase: PH_HOLD, default: '0};
        else        s_q <= s_d;
    end

    assign req  = (s_q.phase == PH_FETCH);
    assign addr = VEC_BASE + ADDR_W'(s_q.idx);
    assign pc   = s_q.pc;
    assign run  = (s_q.phase == PH_RUN);
endmodule

// File: rtl/rst_hub.sv
`timescale 1ns/1ps
module rst_hub
    import rst_hub_pkg::*;
#(
    parameter int                HOLD        = 16,
    parameter int                SYNC_STAGES = 2,
    parameter int                CTL_W       = 8,
    parameter logic [CTL_W-1:0]  RETAIN_MASK = 8'hF0,
    parameter int                NREG        = 12,
    parameter int                REG_W       = 16,
    parameter int                ADDR_W      = 20,
    parameter int                DATA_W      = 8,
    parameter logic [ADDR_W-1:0] VEC_BASE    = 20'hFFFFC,
    localparam int               SEL_W       = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sw_rst_wr,
    input  logic              main_clk_sel,
    input  logic              main_osc_stable,
    input  logic              wdt_uflow,
    input  logic              wdt_rst_en,
    input  logic              osc_stop,
    input  logic              osc_int_mode,
    input  logic              cause_clr_wr,
    input  logic [NCAUSE-1:0] cause_clr_data,
    input  logic              mode_wr,
    input  logic [1:0]        mode_wdata,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              vec_rvalid,
    input  logic [DATA_W-1:0] vec_rdata,
    output logic              sys_rst_o,
    output logic [NCAUSE-1:0] cause_o,
    output logic [1:0]        mode_o,
    output logic [CTL_W-1:0]  ctl_o,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              vec_req_o,
    output logic [ADDR_W-1:0] vec_addr_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic              cpu_run_o,
    output logic              wdt_irq_o,
    output logic              osc_irq_o
);
    localparam int INTB_IDX = NREG - 1;

    typedef struct packed {
        logic [NCAUSE-1:0]            cause;
        logic [1:0]                   mode;
        logic [CTL_W-1:0]             ctl;
        logic [NREG-1:0][ADDR_W-1:0]  regs;
    } hub_st_t;

    localparam hub_st_t ST_RST = '{
        cause: NCAUSE'(1) << CAUSE_POR,
        mode:  '0,
        ctl:   '0,
        regs:  '0
    };

    logic              por_rst_n;
    logic              osc_sync;
    logic [NCAUSE-1:0] trig;
    logic              trig_any;
    logic              wr_open;
    logic              release_now;
    hub_st_t           s_d, s_q;

    rst_hub_sync #(.STAGES(SYNC_STAGES), .ASYNC_CLR(1'b1)) u_por_sync (
        .clk    (clk),
        .arst_n (por_n),
        .din    (1'b1),
        .dout   (por_rst_n)
    );

    rst_hub_sync #(.STAGES(SYNC_STAGES), .ASYNC_CLR(1'b0)) u_osc_sync (
        .clk    (clk),
        .arst_n (por_rst_n),
        .din    (osc_stop),
        .dout   (osc_sync)
    );

    rst_hub_cause u_cause (
        .clk          (clk),
        .rst_n        (por_rst_n),
        .sw_req       (sw_rst_wr),
        .clk_sel      (main_clk_sel),
        .osc_stable   (main_osc_stable),
        .wdt_uflow    (wdt_uflow),
        .wdt_rst_en   (wdt_rst_en),
        .osc_flag     (osc_sync),
        .osc_int_mode (osc_int_mode),
        .trig         (trig),
        .wdt_irq      (wdt_irq_o),
        .osc_irq      (osc_irq_o)
    );

    assign trig_any = |trig;

    rst_hub_stretch #(.HOLD(HOLD)) u_stretch (
        .clk         (clk),
        .rst_n       (por_rst_n),
        .trig_any    (trig_any),
        .active      (sys_rst_o),
        .release_now (release_now)
    );

    rst_hub_vfetch #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .VEC_BASE (VEC_BASE)
    ) u_vfetch (
        .clk         (clk),
        .rst_n       (por_rst_n),
        .restart     (trig_any),
        .release_now (release_now),
        .rvalid      (vec_rvalid),
        .rdata       (vec_rdata),
        .req         (vec_req_o),
        .addr        (vec_addr_o),
        .pc          (pc_o),
        .run         (cpu_run_o)
    );

    always_comb begin
        wr_open = ~sys_rst_o & ~trig_any;
        s_d     = s_q;

        if (cause_clr_wr) s_d.cause = s_q.cause & ~cause_clr_data;
        s_d.cause = s_d.cause | trig;

        if (wr_open && mode_wr) s_d.mode = mode_wdata;
        if (wr_open && ctl_wr)  s_d.ctl  = ctl_wdata;

        if (wr_open && cpu_run_o && reg_wr && (int'(reg_sel) < NREG)) begin
            if (int'(reg_sel) == INTB_IDX)
                s_d.regs[reg_sel] = reg_wdata;
            else
                s_d.regs[reg_sel] = {{(ADDR_W-REG_W){1'b0}}, reg_wdata[REG_W-1:0]};
        end

        if (trig_any) begin
            s_d.ctl  = s_q.ctl & RETAIN_MASK;
            s_d.regs = '0;
        end
    end

    always_ff @(posedge clk or negedge por_rst_n) begin
        if (!por_rst_n) s_q <= ST_RST;
        else            s_q <= s_d;
    end

    assign cause_o   = s_q.cause;
    assign mode_o    = s_q.mode;
    assign ctl_o     = s_q.ctl;
    assign reg_rdata = (int'(reg_sel) < NREG) ? s_q.regs[reg_sel] : '0;
endmodule

// File: rtl/rst_hub_chk.sv
`timescale 1ns/1ps
module rst_hub_chk #(
    parameter int HOLD = 16
) (
    input logic        clk,
    input logic        por_rst_n,
    input logic        sw_rst_wr,
    input logic        main_clk_sel,
    input logic        main_osc_stable,
    input logic        wdt_uflow,
    input logic        wdt_rst_en,
    input logic        cause_clr_wr,
    input logic        sys_rst_o,
    input logic [3:0]  cause_o,
    input logic [1:0]  mode_o,
    input logic [19:0] pc_o,
    input logic        cpu_run_o,
    input logic        vec_req_o,
    input logic [19:0] vec_addr_o,
    input logic        wdt_irq_o
);
    logic [15:0] run_len_q;

    always_ff @(posedge clk or negedge por_rst_n) begin
        if (!por_rst_n)          run_len_q <= '0;
        else if (!sys_rst_o)     run_len_q <= '0;
        else if (run_len_q != '1) run_len_q <= run_len_q + 1'b1;
    end

    assert_sw_reset_R1: assert property (@(posedge clk) disable iff (!por_rst_n)
        (sw_rst_wr && main_clk_sel && main_osc_stable) |=> (sys_rst_o && cause_o[1]));

    assert_wdt_reset_R3: assert property (@(posedge clk) disable iff (!por_rst_n)
        (wdt_uflow && wdt_rst_en) |=> (sys_rst_o && cause_o[2] && !wdt_irq_o));

    assert_wdt_irq_R3: assert property (@(posedge clk) disable iff (!por_rst_n)
        (wdt_uflow && !wdt_rst_en) |=> wdt_irq_o);

    assert_mode_kept_R5: assert property (@(posedge clk) disable iff (!por_rst_n)
        $rose(sys_rst_o) |-> $stable(mode_o));

    assert_pc_held_R9: assert property (@(posedge clk) disable iff (!por_rst_n)
        sys_rst_o |-> (pc_o == 20'h0 && !cpu_run_o));

    assert_vec_window_R9: assert property (@(posedge clk) disable iff (!por_rst_n)
        vec_req_o |-> (vec_addr_o >= 20'hFFFFC && vec_addr_o <= 20'hFFFFE));

    assert_hold_len_R10: assert property (@(posedge clk) disable iff (!por_rst_n)
        $fell(sys_rst_o) |-> (run_len_q >= 16'(HOLD)));

    assert_cause_sticky_R11: assert property (@(posedge clk) disable iff (!por_rst_n)
        !cause_clr_wr |=> ((cause_o & $past(cause_o)) == $past(cause_o)));
endmodule

bind rst_hub rst_hub_chk #(.HOLD(HOLD)) u_chk (.*);

// File: tb/rst_hub_bench.sv
`timescale 1ns/1ps
module rst_hub_bench;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sw_rst_wr = 1'b0, main_clk_sel = 1'b1, main_osc_stable = 1'b1;
    logic        wdt_uflow = 1'b0, wdt_rst_en = 1'b1;
    logic        osc_stop = 1'b0, osc_int_mode = 1'b0;
    logic        cause_clr_wr = 1'b0;
    logic [3:0]  cause_clr_data = '0;
    logic        mode_wr = 1'b0;
    logic [1:0]  mode_wdata = '0;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [19:0] reg_wdata = '0;
    logic        vec_rvalid;
    logic [7:0]  vec_rdata;
    logic        sys_rst_o;
    logic [3:0]  cause_o;
    logic [1:0]  mode_o;
    logic [7:0]  ctl_o;
    logic [19:0] reg_rdata, vec_addr_o, pc_o;
    logic        vec_req_o, cpu_run_o, wdt_irq_o, osc_irq_o;

    int n_chk = 0;
    int n_err = 0;
    logic [19:0] alog [3];
    int          acnt = 0;

    localparam logic [19:0] PC_EXP = 20'h51234;

    always #4 clk = ~clk;

    assign vec_rvalid = vec_req_o;
    assign vec_rdata  = (vec_addr_o == 20'hFFFFC) ? 8'h34 :
                        (vec_addr_o == 20'hFFFFD) ? 8'h12 :
                        (vec_addr_o == 20'hFFFFE) ? 8'hA5 : 8'h00;

    always @(negedge clk) begin
        if (vec_req_o && acnt < 3) begin
            alog[acnt] = vec_addr_o;
            acnt++;
        end
    end

    rst_hub u_rst_hub (.*);

    // fields: src[10:9] wen[8] omode[7] sel[6] stb[5] exp_rst[4] exp_cause[3:0]
    // src: 0 software, 1 watchdog, 2 oscillator stop, 3 software+watchdog
    localparam logic [10:0] TBL [8] = '{
        {2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0010},
        {2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0000},
        {2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000},
        {2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0100},
        {2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0000},
        {2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'b1000},
        {2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'b0000},
        {2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0110}
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic do_por();
        por_n = 1'b0;
        cyc(2);
        chk("R7 sys_rst during por", 32'(sys_rst_o), 32'd1);
        por_n = 1'b1;
        cyc(30);
    endtask

    task automatic clear_causes();
        cause_clr_wr = 1'b1; cause_clr_data = 4'hF;
        cyc(1);
        cause_clr_wr = 1'b0; cause_clr_data = 4'h0;
    endtask

    initial begin
        cyc(1);
        do_por();
        chk("R7 cause after por", 32'(cause_o), 32'h1);
        chk("R7 mode after por", 32'(mode_o), 32'h0);
        chk("R7 ctl after por", 32'(ctl_o), 32'h0);
        chk("R9 pc after por", 32'(pc_o), 32'(PC_EXP));
        chk("R9 run after por", 32'(cpu_run_o), 32'd1);
        chk("R9 vec addr 0", 32'(alog[0]), 32'hFFFFC);
        chk("R9 vec addr 1", 32'(alog[1]), 32'hFFFFD);
        chk("R9 vec addr 2", 32'(alog[2]), 32'hFFFFE);

        // table of vectors
        for (int i = 0; i < 8; i++) begin
            logic [10:0] e;
            string tag;
            e = TBL[i];
            case (e[10:9])
                2'd0:    tag = e[4] ? "R1" : "R2";
                2'd1:    tag = "R3";
                2'd2:    tag = "R4";
                default: tag = "R11";
            endcase
            clear_causes();
            chk({tag, " cause cleared"}, 32'(cause_o), 32'h0);
            wdt_rst_en = e[8]; osc_int_mode = e[7];
            main_clk_sel = e[6]; main_osc_stable = e[5];
            sw_rst_wr = (e[10:9] == 2'd0) || (e[10:9] == 2'd3);
            wdt_uflow = (e[10:9] == 2'd1) || (e[10:9] == 2'd3);
            osc_stop  = (e[10:9] == 2'd2);
            cyc(1);
            sw_rst_wr = 1'b0; wdt_uflow = 1'b0; osc_stop = 1'b0;
            cyc(3);
            chk({tag, " reset out"}, 32'(sys_rst_o), 32'(e[4]));
            chk({tag, " cause bits"}, 32'(cause_o), 32'(e[3:0]));
            if (!e[4]) chk({tag, " pc unchanged"}, 32'(pc_o), 32'(PC_EXP));
            cyc(30);
            chk({tag, " pc after"}, 32'(pc_o), 32'(PC_EXP));
            main_clk_sel = 1'b1; main_osc_stable = 1'b1;
            wdt_rst_en = 1'b1; osc_int_mode = 1'b0;
        end

        // R10: stretch length
        begin
            int n;
            wdt_uflow = 1'b1; cyc(1); wdt_uflow = 1'b0;
            n = 0;
            while (sys_rst_o && n < 100) begin n++; cyc(1); end
            chk("R10 hold length", 32'(n), 32'd16);
            cyc(10);
            wdt_uflow = 1'b1; cyc(1); wdt_uflow = 1'b0;
            cyc(7);
            chk("R10 still high before retrigger", 32'(sys_rst_o), 32'd1);
            wdt_uflow = 1'b1; cyc(1); wdt_uflow = 1'b0;
            n = 0;
            while (sys_rst_o && n < 100) begin n++; cyc(1); end
            chk("R10 retrigger restarts count", 32'(n), 32'd16);
            cyc(10);
        end

        // R5 R6 R8: retained state
        mode_wr = 1'b1; mode_wdata = 2'b10; ctl_wr = 1'b1; ctl_wdata = 8'hFF;
        cyc(1);
        mode_wr = 1'b0; ctl_wr = 1'b0;
        reg_wr = 1'b1; reg_sel = 4'd0; reg_wdata = 20'hFBEEF;
        cyc(1);
        reg_sel = 4'd11; reg_wdata = 20'hABCDE;
        cyc(1);
        reg_wr = 1'b0;
        reg_sel = 4'd0;  #1 chk("R8 16-bit write", 32'(reg_rdata), 32'h0BEEF);
        reg_sel = 4'd11; #1 chk("R8 table base write", 32'(reg_rdata), 32'hABCDE);
        cyc(1);
        sw_rst_wr = 1'b1; cyc(1); sw_rst_wr = 1'b0;
        cyc(2);
        chk("R8 table base cleared", 32'(reg_rdata), 32'h0);
        mode_wr = 1'b1; mode_wdata = 2'b01; cyc(1); mode_wr = 1'b0;
        chk("R5 mode write ignored in reset", 32'(mode_o), 32'h2);
        cyc(30);
        chk("R5 mode kept", 32'(mode_o), 32'h2);
        chk("R6 ctl masked", 32'(ctl_o), 32'hF0);
        reg_sel = 4'd0; #1 chk("R8 reg0 cleared", 32'(reg_rdata), 32'h0);

        // R11: clear semantics
        clear_causes();
        wdt_uflow = 1'b1; cause_clr_wr = 1'b1; cause_clr_data = 4'b0100;
        cyc(1);
        wdt_uflow = 1'b0; cause_clr_wr = 1'b0; cause_clr_data = 4'h0;
        chk("R11 set wins over clear", 32'(cause_o), 32'h4);
        cyc(30);
        chk("R11 survives internal reset", 32'(cause_o), 32'h4);
        cause_clr_wr = 1'b1; cause_clr_data = 4'b0100; cyc(1); cause_clr_wr = 1'b0;
        chk("R11 write-one clears", 32'(cause_o), 32'h0);

        // R3 R4: interrupt pulses
        wdt_rst_en = 1'b0; wdt_uflow = 1'b1; cyc(1); wdt_uflow = 1'b0;
        chk("R3 wdt irq pulse", 32'(wdt_irq_o), 32'd1);
        cyc(1);
        chk("R3 wdt irq one cycle", 32'(wdt_irq_o), 32'd0);
        chk("R3 no reset in irq mode", 32'(sys_rst_o), 32'd0);
        wdt_rst_en = 1'b1;
        osc_int_mode = 1'b1; osc_stop = 1'b1;
        cyc(3);
        chk("R4 osc irq pulse", 32'(osc_irq_o), 32'd1);
        cyc(1);
        chk("R4 osc irq one cycle", 32'(osc_irq_o), 32'd0);
        chk("R4 no reset in irq mode", 32'(sys_rst_o), 32'd0);
        osc_stop = 1'b0; cyc(4); osc_int_mode = 1'b0;

        // R7: power-on clears retained state
        do_por();
        chk("R7 mode cleared", 32'(mode_o), 32'h0);
        chk("R7 ctl cleared", 32'(ctl_o), 32'h0);
        chk("R7 cause por only", 32'(cause_o), 32'h1);
        chk("R9 run after second por", 32'(cpu_run_o), 32'd1);

        finish_run();
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule